// File: doc/BRIEF.md
# Dual-Mode Flit Packet Parser

This block sits at the receive end of a narrow die-to-die link. It takes one 40-bit flit per handshake and rebuilds transactions from them. The flit that opens a packet is marked with a start-of-packet strobe. Its top bit picks one of two field layouts. The compact layout carries a command and a 36-bit address. A write in this layout takes a second flit that holds the data. The routed layout carries a destination tag, a transaction tag, a virtual-channel number and a payload length. It may be followed by any number of payload flits.

Every decoded beat leaves through a one-entry output register that uses its own valid/ready handshake. The input is ready only when that register is empty or is being drained in the same cycle, so a stalled consumer stops the link and no flit is lost. The block flags two kinds of bad input with a one-cycle error pulse. One is a flit without the start strobe where a header is expected. The other is a header with an unknown command. After either fault the parser discards flits until the next start strobe.

The state machine has four states:
- HEAD waits for a header.
- WDATA waits for the data flit of a compact write.
- BODY counts routed payload flits.
- SKIP discards flits after a fault.

Its transitions are:
- HEAD or SKIP to WDATA on a compact write header.
- HEAD or SKIP to BODY on a routed header whose length is not zero.
- HEAD or SKIP to SKIP on a fault.
- WDATA to HEAD on the data flit.
- BODY to HEAD on the last payload flit.
- HEAD or SKIP to HEAD on any header that completes in one flit.

Top module: `flit_parser`

## Requirements
- R1: After reset, txn_valid and err_pulse are 0 and flit_ready is 1.
- R2: A compact header (bit 39 = 0, bits 38:36 = command, bits 35:0 = operand) with command 0 (read request), 1 (read response) or 3 (write ack) yields one beat in the cycle after it is accepted. The beat has txn_ext=0, txn_last=1 and zero tags. Read response puts the operand zero-extended in txn_data with txn_addr=0. The other two put it in txn_addr with txn_data=0.
- R3: A compact header with command 2 (write request) yields no beat. The next accepted flit yields one beat whose txn_addr is the header operand and whose txn_data is that whole flit, with txn_last=1.
- R4: A routed header (bit 39 = 1) has these fields: command in bits 38:36, destination tag in 35:30, transaction tag in 29:24, virtual channel in 23:22 and length in 15:0. With length N > 0, each of the next N accepted flits yields one beat with txn_ext=1, the header command and tags, txn_addr=0 and txn_data equal to the flit. txn_last is 1 only on the Nth beat.
- R5: A routed header with length 0 yields one beat with txn_data=0, txn_last=1 and the header tags.
- R6: A header with command 4 to 7, in either layout, yields no beat. It raises err_pulse for the one cycle after acceptance. Flits without the start strobe that follow are then discarded silently until the next start strobe.
- R7: A flit without the start strobe that arrives in HEAD is discarded and raises err_pulse for one cycle.
- R8: While txn_valid=1 and txn_ready=0, flit_ready is 0 and every txn_* output holds its value.
- R9: The start strobe is ignored on the data flit of a compact write and on routed payload flits. Those flits are taken as data.
- R10: Bits 21:16 of a routed header have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flit_valid | input | 1 | Flit offered |
| flit_ready | output | 1 | Flit can be taken this cycle |
| flit_sop | input | 1 | Flit starts a packet |
| flit_data | input | 40 | Flit contents |
| txn_valid | output | 1 | Decoded beat present |
| txn_ready | input | 1 | Consumer takes the beat |
| txn_ext | output | 1 | Beat comes from a routed packet |
| txn_cmd | output | 3 | Command code |
| txn_addr | output | 36 | Address operand |
| txn_data | output | 40 | Data operand |
| txn_did | output | 6 | Destination tag |
| txn_tid | output | 6 | Transaction tag |
| txn_vc | output | 2 | Virtual channel |
| txn_last | output | 1 | Final beat of the packet |
| err_pulse | output | 1 | One-cycle fault indication |

## Verification
Each beat and each error pulse appears one register stage after the clock edge that accepts the flit that completes it. The bench therefore samples both a short time after the falling edge that follows that clock edge. It compares beats in handshake order against a queue of expected beats, which is filled when the matching packet is generated. Error pulses are counted and compared with the expected fault count once each directed case has settled. Stall behaviour is checked on every cycle in which the output is held. In each such cycle flit_ready must be low and the beat must match the one seen in the cycle before.

// File: rtl/flit_pkg.sv
package flit_pkg;
    typedef enum logic [1:0] {
        S_HEAD  = 2'd0,
        S_WDATA = 2'd1,
        S_BODY  = 2'd2,
        S_SKIP  = 2'd3
    } pstate_t;

    localparam logic [2:0] CMD_RD_REQ = 3'd0;
    localparam logic [2:0] CMD_RD_RSP = 3'd1;
    localparam logic [2:0] CMD_WR_REQ = 3'd2;
    localparam logic [2:0] CMD_WR_ACK = 3'd3;

    function automatic logic cmd_known(input logic [2:0] c);
        return (c <= CMD_WR_ACK);
    endfunction
endpackage

// File: rtl/flit_hdr_dec.sv
module flit_hdr_dec #(
    parameter int FLIT_W = 40,
    parameter int ID_W   = 6,
    parameter int VC_W   = 2,
    parameter int LEN_W  = 16
) (
    input  logic [FLIT_W-1:0]        flit,
    output logic                     ext,
    output logic [2:0]               cmd,
    output logic                     known,
    output logic [FLIT_W-5:0]        opnd,
    output logic [ID_W-1:0]          did,
    output logic [ID_W-1:0]          tid,
    output logic [VC_W-1:0]          vc,
    output logic [LEN_W-1:0]         len
);
    import flit_pkg::*;

    localparam int MODE_BIT = FLIT_W - 1;
    localparam int CMD_LO   = FLIT_W - 4;
    localparam int DID_LO   = CMD_LO - ID_W;
    localparam int TID_LO   = DID_LO - ID_W;
    localparam int VC_LO    = TID_LO - VC_W;

    always_comb begin
        ext   = flit[MODE_BIT];
        cmd   = flit[MODE_BIT-1:CMD_LO];
        known = cmd_known(cmd);
        opnd  = flit[CMD_LO-1:0];
        did   = flit[CMD_LO-1:DID_LO];
        tid   = flit[DID_LO-1:TID_LO];
        vc    = flit[TID_LO-1:VC_LO];
        len   = flit[LEN_W-1:0];
    end
endmodule

// File: rtl/flit_parse_fsm.sv
module flit_parse_fsm #(
    parameter int FLIT_W = 40,
    parameter int ID_W   = 6,
    parameter int VC_W   = 2,
    parameter int LEN_W  = 16,
    localparam int ADDR_W = FLIT_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              sop,
    input  logic [FLIT_W-1:0] flit,
    input  logic              d_ext,
    input  logic [2:0]        d_cmd,
    input  logic              d_known,
    input  logic [ADDR_W-1:0] d_opnd,
    input  logic [ID_W-1:0]   d_did,
    input  logic [ID_W-1:0]   d_tid,
    input  logic [VC_W-1:0]   d_vc,
    input  logic [LEN_W-1:0]  d_len,
    input  logic              txn_ready,
    output logic              txn_valid,
    output logic              txn_ext,
    output logic [2:0]        txn_cmd,
    output logic [ADDR_W-1:0] txn_addr,
    output logic [FLIT_W-1:0] txn_data,
    output logic [ID_W-1:0]   txn_did,
    output logic [ID_W-1:0]   txn_tid,
    output logic [VC_W-1:0]   txn_vc,
    output logic              txn_last,
    output logic              err_pulse
);
    import flit_pkg::*;

    pstate_t state, nxt;

    logic [2:0]        h_cmd;
    logic [ADDR_W-1:0] h_addr;
    logic [ID_W-1:0]   h_did, h_tid;
    logic [VC_W-1:0]   h_vc;
    logic [LEN_W-1:0]  rem;

    logic              emit, err_d, ld_hdr, ld_rem, dec_rem;
    logic              e_ext, e_last;
    logic [2:0]        e_cmd;
    logic [ADDR_W-1:0] e_addr;
    logic [FLIT_W-1:0] e_data;
    logic [ID_W-1:0]   e_did, e_tid;
    logic [VC_W-1:0]   e_vc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HEAD;
        else        state <= nxt;
    end

    // transitions and beat formation
    always_comb begin
        nxt = state;
        emit = 1'b0; err_d = 1'b0;
        ld_hdr = 1'b0; ld_rem = 1'b0; dec_rem = 1'b0;
        e_ext = 1'b0; e_last = 1'b1; e_cmd = d_cmd;
        e_addr = '0; e_data = '0;
        e_did = '0; e_tid = '0; e_vc = '0;
        if (acc) begin
            unique case (state)
                S_HEAD, S_SKIP: begin
                    if (!sop) begin
                        err_d = (state == S_HEAD);
                        nxt   = S_SKIP;
                    end else if (!d_known) begin
                        err_d = 1'b1;
                        nxt   = S_SKIP;
                    end else if (!d_ext) begin
                        if (d_cmd == CMD_WR_REQ) begin
                            ld_hdr = 1'b1;
                            nxt    = S_WDATA;
                        end else begin
                            emit = 1'b1;
                            nxt  = S_HEAD;
                            if (d_cmd == CMD_RD_RSP)
                                e_data = {{(FLIT_W-ADDR_W){1'b0}}, d_opnd};
                            else
                                e_addr = d_opnd;
                        end
                    end else if (d_len == '0) begin
                        emit  = 1'b1;
                        e_ext = 1'b1;
                        e_did = d_did; e_tid = d_tid; e_vc = d_vc;
                        nxt   = S_HEAD;
                    end else begin
                        ld_hdr = 1'b1;
                        ld_rem = 1'b1;
                        nxt    = S_BODY;
                    end
                end
                S_WDATA: begin
                    emit   = 1'b1;
                    e_cmd  = h_cmd;
                    e_addr = h_addr;
                    e_data = flit;
                    nxt    = S_HEAD;
                end
                S_BODY: begin
                    emit    = 1'b1;
                    dec_rem = 1'b1;
                    e_ext   = 1'b1;
                    e_cmd   = h_cmd;
                    e_data  = flit;
                    e_did = h_did; e_tid = h_tid; e_vc = h_vc;
                    e_last  = (rem == LEN_W'(1));
                    if (rem == LEN_W'(1)) nxt = S_HEAD;
                end
            endcase
        end
    end

    // header capture and payload counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cmd <= '0; h_addr <= '0; h_did <= '0; h_tid <= '0; h_vc <= '0;
            rem <= '0;
        end else begin
            if (ld_hdr) begin
                h_cmd <= d_cmd; h_addr <= d_opnd;
                h_did <= d_did; h_tid <= d_tid; h_vc <= d_vc;
            end
            if (ld_rem)       rem <= d_len;
            else if (dec_rem) rem <= rem - LEN_W'(1);
        end
    end

    // output slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txn_valid <= 1'b0; err_pulse <= 1'b0;
            txn_ext <= 1'b0; txn_cmd <= '0; txn_addr <= '0; txn_data <= '0;
            txn_did <= '0; txn_tid <= '0; txn_vc <= '0; txn_last <= 1'b0;
        end else begin
            err_pulse <= err_d;
            if (emit) begin
                txn_valid <= 1'b1;
                txn_ext <= e_ext; txn_cmd <= e_cmd;
                txn_addr <= e_addr; txn_data <= e_data;
                txn_did <= e_did; txn_tid <= e_tid; txn_vc <= e_vc;
                txn_last <= e_last;
            end else if (txn_ready) begin
                txn_valid <= 1'b0;
            end
        end
    end

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |=> txn_valid && $stable(txn_data)
            && $stable(txn_addr) && $stable(txn_cmd) && $stable(txn_last));

    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !txn_valid);

    p_lw_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ext |-> txn_last);

    p_beat_needs_flit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txn_valid) |-> $past(acc));

    p_skip_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_SKIP && acc && !sop |=> !err_pulse && !$rose(txn_valid));
endmodule

// File: rtl/flit_parser.sv
module flit_parser #(
    parameter int FLIT_W = 40,
    parameter int ID_W   = 6,
    parameter int VC_W   = 2,
    parameter int LEN_W  = 16,
    localparam int ADDR_W = FLIT_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flit_valid,
    output logic              flit_ready,
    input  logic              flit_sop,
    input  logic [FLIT_W-1:0] flit_data,
    output logic              txn_valid,
    input  logic              txn_ready,
    output logic              txn_ext,
    output logic [2:0]        txn_cmd,
    output logic [ADDR_W-1:0] txn_addr,
    output logic [FLIT_W-1:0] txn_data,
    output logic [ID_W-1:0]   txn_did,
    output logic [ID_W-1:0]   txn_tid,
    output logic [VC_W-1:0]   txn_vc,
    output logic              txn_last,
    output logic              err_pulse
);
    logic              d_ext, d_known;
    logic [2:0]        d_cmd;
    logic [ADDR_W-1:0] d_opnd;
    logic [ID_W-1:0]   d_did, d_tid;
    logic [VC_W-1:0]   d_vc;
    logic [LEN_W-1:0]  d_len;
    logic              acc;

    assign flit_ready = !txn_valid || txn_ready;
    assign acc        = flit_valid && flit_ready;

    flit_hdr_dec #(.FLIT_W(FLIT_W), .ID_W(ID_W), .VC_W(VC_W), .LEN_W(LEN_W)) u_dec (
        .flit(flit_data), .ext(d_ext), .cmd(d_cmd), .known(d_known),
        .opnd(d_opnd), .did(d_did), .tid(d_tid), .vc(d_vc), .len(d_len)
    );

    flit_parse_fsm #(.FLIT_W(FLIT_W), .ID_W(ID_W), .VC_W(VC_W), .LEN_W(LEN_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .acc(acc), .sop(flit_sop), .flit(flit_data),
        .d_ext(d_ext), .d_cmd(d_cmd), .d_known(d_known), .d_opnd(d_opnd),
        .d_did(d_did), .d_tid(d_tid), .d_vc(d_vc), .d_len(d_len),
        .txn_ready(txn_ready), .txn_valid(txn_valid), .txn_ext(txn_ext),
        .txn_cmd(txn_cmd), .txn_addr(txn_addr), .txn_data(txn_data),
        .txn_did(txn_did), .txn_tid(txn_tid), .txn_vc(txn_vc),
        .txn_last(txn_last), .err_pulse(err_pulse)
    );

    p_stall_blocks_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid && !txn_ready |-> !flit_ready);
endmodule

// File: tb/test_flit_parser.sv
module test_flit_parser;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flit_valid = 1'b0;
    logic        flit_ready;
    logic        flit_sop = 1'b0;
    logic [39:0] flit_data = '0;
    logic        txn_valid;
    logic        txn_ready = 1'b0;
    logic        txn_ext;
    logic [2:0]  txn_cmd;
    logic [35:0] txn_addr;
    logic [39:0] txn_data;
    logic [5:0]  txn_did, txn_tid;
    logic [1:0]  txn_vc;
    logic        txn_last;
    logic        err_pulse;

    flit_parser i_flit_parser (
        .clk(clk), .rst_n(rst_n), .flit_valid(flit_valid), .flit_ready(flit_ready),
        .flit_sop(flit_sop), .flit_data(flit_data), .txn_valid(txn_valid),
        .txn_ready(txn_ready), .txn_ext(txn_ext), .txn_cmd(txn_cmd),
        .txn_addr(txn_addr), .txn_data(txn_data), .txn_did(txn_did),
        .txn_tid(txn_tid), .txn_vc(txn_vc), .txn_last(txn_last),
        .err_pulse(err_pulse)
    );

    always #4 clk = ~clk;

    typedef logic [94:0] beat_t;
    beat_t exp_q[$];
    string tag_q[$];
    int n_chk = 0, n_bad = 0, err_seen = 0, err_exp = 0, cyc = 0;
    int rdy_mode = 0;   // 0 random, 1 high, 2 low
    bit done = 1'b0;
    bit prev_blk = 1'b0;
    beat_t prev_beat = '0;
    int unsigned seed_dummy;

    function automatic beat_t mk(input logic e, input logic [2:0] c, input logic [35:0] a,
                                 input logic [39:0] d, input logic [5:0] di,
                                 input logic [5:0] ti, input logic [1:0] v, input logic l);
        return {e, c, a, d, di, ti, v, l};
    endfunction

    function automatic beat_t act_beat();
        return {txn_ext, txn_cmd, txn_addr, txn_data, txn_did, txn_tid, txn_vc, txn_last};
    endfunction

    task automatic check(input bit ok, input string tag, input beat_t a, input beat_t e);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            summary();
        end
    end

    // monitor: sets consumer ready, then samples in the low phase
    always @(negedge clk) begin
        if (rdy_mode == 1)      txn_ready = 1'b1;
        else if (rdy_mode == 2) txn_ready = 1'b0;
        else                    txn_ready = (($urandom % 4) != 0);
        #1;
        if (rst_n) begin
            if (err_pulse) err_seen++;
            if (prev_blk) begin
                check(txn_valid && act_beat() == prev_beat, "R8 held beat",
                      act_beat(), prev_beat);
            end
            if (txn_valid && !txn_ready)
                check(!flit_ready, "R8 input stalled", beat_t'(flit_ready), '0);
            if (txn_valid && txn_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected beat", act_beat(), '0);
                end else begin
                    beat_t e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(act_beat() == e, t, act_beat(), e);
                end
            end
            prev_blk  = txn_valid && !txn_ready;
            prev_beat = act_beat();
        end
    end

    task automatic send(input logic sop, input logic [39:0] d);
        bit a;
        do begin
            @(negedge clk);
            flit_valid = 1'b1; flit_sop = sop; flit_data = d;
            #2;
            a = flit_ready;
        end while (!a);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            flit_valid = 1'b0; flit_sop = 1'b0;
        end
    endtask

    task automatic lw_pkt(input logic [2:0] c, input logic [35:0] a,
                          input logic [39:0] wd, input logic wsop);
        if (c == 3'd2) begin
            exp_q.push_back(mk(1'b0, c, a, wd, '0, '0, '0, 1'b1));
            tag_q.push_back(wsop ? "R3 R9 write beat" : "R3 write beat");
            send(1'b1, {1'b0, c, a});
            send(wsop, wd);
        end else begin
            if (c == 3'd1) exp_q.push_back(mk(1'b0, c, '0, {4'b0, a}, '0, '0, '0, 1'b1));
            else           exp_q.push_back(mk(1'b0, c, a, '0, '0, '0, '0, 1'b1));
            tag_q.push_back("R2 single flit beat");
            send(1'b1, {1'b0, c, a});
        end
    endtask

    task automatic ext_pkt(input logic [2:0] c, input logic [5:0] di, input logic [5:0] ti,
                           input logic [1:0] v, input logic [5:0] rsv, input int n);
        send(1'b1, {1'b1, c, di, ti, v, rsv, 16'(n)});
        if (n == 0) begin
            exp_q.push_back(mk(1'b1, c, '0, '0, di, ti, v, 1'b1));
            tag_q.push_back("R5 R10 empty routed beat");
        end
        for (int i = 0; i < n; i++) begin
            logic [39:0] d;
            logic s;
            d = {$urandom, $urandom} ;
            s = $urandom % 2;
            exp_q.push_back(mk(1'b1, c, '0, d, di, ti, v, i == n - 1));
            tag_q.push_back(s ? "R4 R9 R10 payload beat" : "R4 R10 payload beat");
            send(s, d);
        end
    endtask

    task automatic bad_pkt(input logic [2:0] c, input logic e, input int trail);
        send(1'b1, {e, c, 36'h123456789});
        err_exp++;
        for (int i = 0; i < trail; i++) send(1'b0, {$urandom, $urandom});
    endtask

    task automatic check_err(input string tag);
        idle(3);
        check(err_seen == err_exp, tag, beat_t'(err_seen), beat_t'(err_exp));
    endtask

    initial begin
        seed_dummy = $urandom(32'h0C0FFEE5);
        rdy_mode = 1;
        repeat (4) @(negedge clk);
        #2;
        check(!txn_valid && !err_pulse && flit_ready, "R1 reset state",
              beat_t'({txn_valid, err_pulse, flit_ready}), beat_t'(3'b001));
        @(negedge clk);
        rst_n = 1'b1;

        // directed compact cases
        lw_pkt(3'd0, 36'hF_FFFF_FFFF, '0, 1'b0);
        lw_pkt(3'd1, 36'hA_5A5A_5A5A, '0, 1'b0);
        lw_pkt(3'd3, 36'h0_0000_0001, '0, 1'b0);
        lw_pkt(3'd2, 36'h8_0000_0010, 40'hFF_0000_00FF, 1'b1);
        lw_pkt(3'd2, 36'h0_1234_5678, 40'h80_0000_0001, 1'b0);
        // directed routed cases
        ext_pkt(3'd0, 6'h3F, 6'h00, 2'd3, 6'h3F, 0);
        ext_pkt(3'd2, 6'h15, 6'h2A, 2'd1, 6'h3F, 3);
        ext_pkt(3'd1, 6'h01, 6'h3E, 2'd2, 6'h00, 1);
        check_err("R1 no stray error");

        // faults
        bad_pkt(3'd5, 1'b0, 2);
        lw_pkt(3'd0, 36'h0_0000_BEEF, '0, 1'b0);
        check_err("R6 unknown compact command");
        bad_pkt(3'd7, 1'b1, 0);
        ext_pkt(3'd3, 6'h07, 6'h09, 2'd0, 6'h11, 2);
        check_err("R6 unknown routed command");
        send(1'b0, 40'h12_3456_789A);
        err_exp++;
        send(1'b0, 40'h00_0000_0001);
        lw_pkt(3'd3, 36'h0_0000_0042, '0, 1'b0);
        check_err("R7 orphan flit");

        // stall
        rdy_mode = 2;
        fork
            begin
                lw_pkt(3'd0, 36'h1_1111_1111, '0, 1'b0);
                ext_pkt(3'd2, 6'h22, 6'h33, 2'd1, 6'h05, 2);
            end
        join_none
        repeat (12) @(negedge clk);
        rdy_mode = 0;
        wait fork;

        // random mix
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom % 10;
            if (r == 0)
                bad_pkt(3'(4 + $urandom % 4), 1'($urandom % 2), $urandom % 3);
            else if (r < 5)
                lw_pkt(3'($urandom % 4), {$urandom, 4'($urandom)}, {$urandom, 8'($urandom)},
                       1'($urandom % 2));
            else
                ext_pkt(3'($urandom % 4), 6'($urandom), 6'($urandom), 2'($urandom),
                        6'($urandom), $urandom % 5);
            if ($urandom % 4 == 0) idle($urandom % 3 + 1);
        end
        rdy_mode = 1;
        idle(10);
        check(exp_q.size() == 0, "R4 all beats delivered", beat_t'(exp_q.size()), '0);
        check(err_seen == err_exp, "R6 error count", beat_t'(err_seen), beat_t'(err_exp));
        summary();
    end
endmodule